// File: doc/BRIEF.md
# Double-to-Single Narrowing Converter

This unit takes a 64-bit binary floating-point value and returns the nearest 32-bit binary floating-point value, rounding to nearest with ties to even. Finite operands that leave the narrower range become signed infinity. Operands that fall below the normal range become subnormals or signed zero. Each result comes with four status flags: invalid, overflow, underflow and inexact.

NaNs have their own path. A per-operand mode input selects how the most significant fraction bit is read: legacy encoding or 2008 encoding. A signalling NaN is first quieted the way the selected mode requires, and then it is treated like any quiet NaN. A quiet NaN keeps its sign and the top fraction bits that fit in the narrower format. This means a NaN that was widened earlier comes back with the same payload.

Operands arrive on a valid/ready input port. Results leave on a valid/ready output port through a single output register. A consumer that stalls holds the result in place, and the producer is held off until the register frees up.

Top module: `dpsp_narrow`

## Requirements
- R1: An operand accepted on a clock edge (in_valid and in_ready both high) appears with out_valid high after that edge, so latency is one cycle. in_ready is high exactly when the output register is empty or is being drained in the same cycle. While out_valid is high and out_ready is low, out_valid and out_data hold their values.
- R2: A finite operand whose rounded magnitude falls in the single normal range gives the correctly rounded result, using round to nearest with ties to even. inexact is set exactly when rounding discarded non-zero bits, and no other flag is set.
- R3: A finite operand whose rounded magnitude reaches 2^128 or more gives infinity of the operand's sign (exponent field all ones, fraction zero). Both overflow and inexact are set.
- R4: A finite operand whose unrounded exponent is below the single minimum normal exponent is rounded at the subnormal position, with ties to even. It may round up to the smallest normal value. Double subnormal operands give signed zero. underflow is set when the operand is tiny and the result is inexact. inexact follows R2.
- R5: Infinity and zero keep their sign and convert to single infinity and zero. No flag is raised.
- R6: When in_nan2008 is 0 (legacy), a NaN with fraction bit 51 set is signalling. When in_nan2008 is 1, a NaN with fraction bit 51 clear is signalling. A signalling NaN raises invalid and nothing else. A quiet NaN raises no flag.
- R7: A quiet NaN gives sign unchanged, exponent all ones, and single fraction bits [22:0] taken from double fraction bits [51:29].
- R8: In 2008 mode, a signalling NaN has its fraction bit 51 set and its sign and other payload bits kept. It is then converted as in R7, so the result always has single fraction bit 22 set.
- R9: In legacy mode, a signalling NaN is replaced by the positive legacy default NaN before narrowing, which gives 0x7FBFFFFF.
- R10: In legacy mode, if the truncated single fraction of a quiet NaN is zero, the result is 0x7FBFFFFF.
- R11: After reset, out_valid is low and, once reset has been released internally, in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand present |
| in_ready | output | 1 | Operand will be taken on this edge |
| in_data | input | 64 | Double-precision operand |
| in_nan2008 | input | 1 | NaN encoding of this operand: 0 legacy, 1 2008 |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 32 | Single-precision result |
| out_invalid | output | 1 | Invalid-operation flag for the result |
| out_overflow | output | 1 | Overflow flag for the result |
| out_underflow | output | 1 | Underflow flag for the result |
| out_inexact | output | 1 | Inexact flag for the result |

## Verification
The hardest cases are at the edges of the rounding path. These include exact ties that must round to even, a mantissa of all ones that carries into the exponent, and a subnormal result that rounds up to the smallest normal. To reach them, the stimulus walks every double exponent code, with both signs, and pairs each one with fixed fraction patterns placed around the guard bit (tie-even, tie-odd, just above and just below half, all ones) plus a pseudo-random fraction. The NaN rules are reached by sweeping the top four fraction bits against low-bit patterns under both modes. This covers legacy payloads whose truncation leaves zero.

// File: rtl/dpsp_pkg.sv
package dpsp_pkg;

  typedef enum logic [2:0] {
    CLS_ZERO,
    CLS_FINITE,
    CLS_INF,
    CLS_QNAN,
    CLS_SNAN
  } fcls_e;

  typedef struct packed {
    logic inv;
    logic ovf;
    logic unf;
    logic inx;
  } fflags_t;

endpackage

// File: rtl/dpsp_classify.sv
module dpsp_classify
  import dpsp_pkg::*;
#(
  parameter int EW = 11,
  parameter int FW = 52
) (
  input  logic [EW-1:0] exp_i,
  input  logic [FW-1:0] frac_i,
  input  logic          mode_2008_i,
  output fcls_e         cls_o
);

  always_comb begin
    if (exp_i == '1) begin
      if (frac_i == '0)                      cls_o = CLS_INF;
      else if (mode_2008_i ^ frac_i[FW-1])   cls_o = CLS_SNAN;
      else                                   cls_o = CLS_QNAN;
    end else if (exp_i == '0 && frac_i == '0) begin
      cls_o = CLS_ZERO;
    end else begin
      cls_o = CLS_FINITE;
    end
  end

endmodule

// File: rtl/dpsp_nan_path.sv
module dpsp_nan_path #(
  parameter int DEW = 8,
  parameter int DFW = 23
) (
  input  logic             sign_i,
  input  logic [DFW-1:0]   frac_hi_i,
  input  logic             is_snan_i,
  input  logic             mode_2008_i,
  output logic [DEW+DFW:0] res_o,
  output logic             inv_o
);

  localparam logic [DFW-1:0] LEG_DEFAULT = {1'b0, {(DFW-1){1'b1}}};

  logic           s_q;
  logic [DFW-1:0] f_q;

  always_comb begin
    s_q = sign_i;
    f_q = frac_hi_i;
    if (is_snan_i) begin
      if (mode_2008_i) begin
        f_q[DFW-1] = 1'b1;
      end else begin
        s_q = 1'b0;
        f_q = LEG_DEFAULT;
      end
    end
    if (!mode_2008_i && f_q == '0) begin
      s_q = 1'b0;
      f_q = LEG_DEFAULT;
    end
    res_o = {s_q, {DEW{1'b1}}, f_q};
    inv_o = is_snan_i;
  end

endmodule

// File: rtl/dpsp_round_path.sv
module dpsp_round_path #(
  parameter int SEW = 11,
  parameter int SFW = 52,
  parameter int DEW = 8,
  parameter int DFW = 23
) (
  input  logic             sign_i,
  input  logic [SEW-1:0]   exp_i,
  input  logic [SFW-1:0]   frac_i,
  output logic [DEW+DFW:0] res_o,
  output logic             ovf_o,
  output logic             unf_o,
  output logic             inx_o
);

  localparam int SBIAS = (1 << (SEW-1)) - 1;
  localparam int DBIAS = (1 << (DEW-1)) - 1;
  localparam int EXW   = SEW + 2;
  localparam int SHMAX = SFW + 2;
  localparam int SHW   = $clog2(SHMAX + 1);
  localparam int MW    = SFW + 1;
  localparam logic signed [EXW-1:0] BIAS_DIFF = EXW'(SBIAS - DBIAS);
  localparam logic signed [EXW-1:0] ONE_S     = EXW'(1);
  localparam logic signed [EXW-1:0] EMAX_S    = EXW'((1 << DEW) - 1);

  logic                  hid;
  logic [SEW-1:0]        e_eff;
  logic signed [EXW-1:0] de, deff, neg, expo;
  logic                  tiny;
  logic [SHW-1:0]        sh;
  logic [MW-1:0]         mant, shifted;
  logic                  lost, grd, stk, rnd_up;
  logic [DFW:0]          kept;
  logic [DFW+1:0]        rsum;

  always_comb begin
    hid   = (exp_i != '0);
    e_eff = hid ? exp_i : SEW'(1);
    de    = $signed({2'b00, e_eff}) - BIAS_DIFF;
    tiny  = de[EXW-1] || (de == '0);
    neg   = ONE_S - de;
    if (!tiny)                          sh = '0;
    else if (neg > EXW'(SHMAX))         sh = SHW'(SHMAX);
    else                                sh = neg[SHW-1:0];

    mant    = {hid, frac_i};
    shifted = mant >> sh;
    lost    = |(mant & ~({MW{1'b1}} << sh));
    kept    = shifted[SFW -: DFW+1];
    grd     = shifted[SFW-DFW-1];
    stk     = (|shifted[SFW-DFW-2:0]) | lost;
    rnd_up  = grd & (stk | kept[0]);
    rsum    = {1'b0, kept} + (DFW+2)'(rnd_up);

    deff  = tiny ? ONE_S : de;
    expo  = deff - ONE_S + $signed({{(EXW-2){1'b0}}, rsum[DFW+1:DFW]});
    ovf_o = (expo >= EMAX_S);
    inx_o = grd | stk | ovf_o;
    unf_o = tiny & (grd | stk);
    if (ovf_o) res_o = {sign_i, {DEW{1'b1}}, {DFW{1'b0}}};
    else       res_o = {sign_i, expo[DEW-1:0], rsum[DFW-1:0]};
  end

endmodule

// File: rtl/dpsp_narrow.sv
module dpsp_narrow
  import dpsp_pkg::*;
#(
  parameter int SEW = 11,
  parameter int SFW = 52,
  parameter int DEW = 8,
  parameter int DFW = 23
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [SEW+SFW:0]       in_data,
  input  logic                   in_nan2008,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [DEW+DFW:0]       out_data,
  output logic                   out_invalid,
  output logic                   out_overflow,
  output logic                   out_underflow,
  output logic                   out_inexact
);

  localparam int SW = 1 + SEW + SFW;
  localparam int DW = 1 + DEW + DFW;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       sys_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign sys_rst_n = rst_sync_q[1];

  // operand fields
  logic           op_sign;
  logic [SEW-1:0] op_exp;
  logic [SFW-1:0] op_frac;
  fcls_e          op_cls;

  assign op_sign = in_data[SW-1];
  assign op_exp  = in_data[SW-2 -: SEW];
  assign op_frac = in_data[SFW-1:0];

  dpsp_classify #(.EW(SEW), .FW(SFW)) u_cls (
    .exp_i       (op_exp),
    .frac_i      (op_frac),
    .mode_2008_i (in_nan2008),
    .cls_o       (op_cls)
  );

  logic [DW-1:0] nan_res, num_res;
  logic          nan_inv, num_ovf, num_unf, num_inx;

  dpsp_nan_path #(.DEW(DEW), .DFW(DFW)) u_nan (
    .sign_i      (op_sign),
    .frac_hi_i   (op_frac[SFW-1 -: DFW]),
    .is_snan_i   (op_cls == CLS_SNAN),
    .mode_2008_i (in_nan2008),
    .res_o       (nan_res),
    .inv_o       (nan_inv)
  );

  dpsp_round_path #(.SEW(SEW), .SFW(SFW), .DEW(DEW), .DFW(DFW)) u_num (
    .sign_i (op_sign),
    .exp_i  (op_exp),
    .frac_i (op_frac),
    .res_o  (num_res),
    .ovf_o  (num_ovf),
    .unf_o  (num_unf),
    .inx_o  (num_inx)
  );

  // next-state logic
  logic [DW-1:0] res_d, res_q;
  fflags_t       flg_d, flg_q;
  logic          vld_d, vld_q;
  logic          load_en;

  always_comb begin
    unique case (op_cls)
      CLS_ZERO: begin
        res_d = {op_sign, {(DW-1){1'b0}}};
        flg_d = '0;
      end
      CLS_INF: begin
        res_d = {op_sign, {DEW{1'b1}}, {DFW{1'b0}}};
        flg_d = '0;
      end
      CLS_QNAN, CLS_SNAN: begin
        res_d = nan_res;
        flg_d = '{inv: nan_inv, ovf: 1'b0, unf: 1'b0, inx: 1'b0};
      end
      default: begin
        res_d = num_res;
        flg_d = '{inv: 1'b0, ovf: num_ovf, unf: num_unf, inx: num_inx};
      end
    endcase
  end

  always_comb begin
    in_ready = sys_rst_n & (~vld_q | out_ready);
    load_en  = in_valid & in_ready;
    vld_d    = load_en | (vld_q & ~out_ready);
  end

  // registers
  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n) vld_q <= 1'b0;
    else            vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (load_en) begin
      res_q <= res_d;
      flg_q <= flg_d;
    end
  end

  assign out_valid     = vld_q;
  assign out_data      = res_q;
  assign out_invalid   = flg_q.inv;
  assign out_overflow  = flg_q.ovf;
  assign out_underflow = flg_q.unf;
  assign out_inexact   = flg_q.inx;

endmodule

// File: rtl/dpsp_narrow_chk.sv
module dpsp_narrow_chk #(
  parameter int SEW = 11,
  parameter int SFW = 52,
  parameter int DEW = 8,
  parameter int DFW = 23
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic [SEW+SFW-1:0]   in_body,
  input logic                 in_nan2008,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic [DEW+DFW-1:0]   out_body,
  input logic                 out_invalid,
  input logic                 out_overflow,
  input logic                 out_underflow,
  input logic                 out_inexact
);

  logic [DEW-1:0] o_exp;
  logic [DFW-1:0] o_frac;
  logic           in_is_nan;

  assign o_exp     = out_body[DEW+DFW-1 -: DEW];
  assign o_frac    = out_body[DFW-1:0];
  assign in_is_nan = (in_body[SEW+SFW-1 -: SEW] == '1) && (in_body[SFW-1:0] != '0);

  AST_ACCEPT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid); // R1

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_body)); // R1

  AST_OVF_TO_INF: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_overflow |-> o_exp == '1 && o_frac == '0 && out_inexact); // R3

  AST_UNF_TINY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_underflow |-> out_inexact && o_exp <= DEW'(1)); // R4

  AST_INV_IS_NAN: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_invalid |-> o_exp == '1 && o_frac != '0 &&
      !out_overflow && !out_underflow && !out_inexact); // R6

  AST_2008_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_nan2008 && in_is_nan |=> o_frac[DFW-1]); // R8

endmodule

bind dpsp_narrow dpsp_narrow_chk #(.SEW(SEW), .SFW(SFW), .DEW(DEW), .DFW(DFW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .in_valid      (in_valid),
  .in_ready      (in_ready),
  .in_body       (in_data[SEW+SFW-1:0]),
  .in_nan2008    (in_nan2008),
  .out_valid     (out_valid),
  .out_ready     (out_ready),
  .out_body      (out_data[DEW+DFW-1:0]),
  .out_invalid   (out_invalid),
  .out_overflow  (out_overflow),
  .out_underflow (out_underflow),
  .out_inexact   (out_inexact)
);

// File: tb/sim_dpsp_narrow.sv
module sim_dpsp_narrow;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [63:0] in_data;
  logic        in_nan2008;
  logic        out_valid;
  logic        out_ready;
  logic [31:0] out_data;
  logic        out_invalid, out_overflow, out_underflow, out_inexact;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  dpsp_narrow u0 (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_ready      (in_ready),
    .in_data       (in_data),
    .in_nan2008    (in_nan2008),
    .out_valid     (out_valid),
    .out_ready     (out_ready),
    .out_data      (out_data),
    .out_invalid   (out_invalid),
    .out_overflow  (out_overflow),
    .out_underflow (out_underflow),
    .out_inexact   (out_inexact)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // expected {inv, ovf, unf, inx, result}, computed arithmetically
  function automatic logic [35:0] ref_cvt(logic [63:0] x, logic m2008);
    logic              s, qb, sn, inx, tiny, up;
    logic [51:0]       f;
    logic [22:0]       t;
    int                e, ee, sh, be;
    longint unsigned   mm, q, rem, half;
    s = x[63];
    e = int'(x[62:52]);
    f = x[51:0];
    if (e == 2047) begin
      if (f == '0) return {4'b0000, s, 8'hFF, 23'd0};
      qb = f[51];
      sn = m2008 ? !qb : qb;
      if (sn) begin
        if (m2008) f[51] = 1'b1;
        else begin s = 1'b0; f = 52'h7FFFFFFFFFFFF; end
      end
      t = f[51:29];
      if (!m2008 && t == '0) return {sn, 3'b000, 32'h7FBFFFFF};
      return {sn, 3'b000, s, 8'hFF, t};
    end
    if (e == 0 && f == '0) return {4'b0000, s, 31'd0};
    if (e == 0) begin mm = {12'd0, f};       ee = -1022;     end
    else        begin mm = {11'd0, 1'b1, f}; ee = e - 1023;  end
    tiny = (ee < -126);
    sh   = tiny ? 29 + (-126 - ee) : 29;
    if (sh > 62) begin
      q = 0; rem = mm; up = 1'b0;
    end else begin
      q    = mm >> sh;
      rem  = mm - (q << sh);
      half = 64'd1 << (sh - 1);
      up   = (rem > half) || (rem == half && q[0]);
    end
    q   = q + {63'd0, up};
    inx = (rem != 0);
    if (!tiny) begin
      if (q == (64'd1 << 24)) begin q = 64'd1 << 23; ee = ee + 1; end
      be = ee + 127;
      if (be >= 255) return {4'b0101, s, 8'hFF, 23'd0};
      return {3'b000, inx, s, be[7:0], q[22:0]};
    end
    if (q == (64'd1 << 23)) return {2'b00, inx, inx, s, 8'd1, 23'd0};
    return {2'b00, inx, inx, s, 8'd0, q[22:0]};
  endfunction

  function automatic string tag_of(logic [63:0] x, logic m2008, logic [35:0] ex);
    if (x[62:52] == 11'h7FF) begin
      if (x[51:0] == '0) return "R5";
      if (ex[35]) return m2008 ? "R6 R8" : "R6 R9";
      if (!m2008 && x[51:29] == '0) return "R6 R10";
      return "R6 R7";
    end
    if (x[62:0] == '0) return "R5";
    if (ex[34]) return "R3";
    if (x[62:52] < 11'd897) return "R4";
    return "R2";
  endfunction

  task automatic chk(bit ok, string tag, logic [35:0] act, logic [35:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s in=%h actual=%h expected=%h", tag, in_data, act, exp);
    end
  endtask

  task automatic run_vec(logic [63:0] x, logic m2008);
    logic [35:0] ex, act;
    ex = ref_cvt(x, m2008);
    @(negedge clk);
    in_data    = x;
    in_nan2008 = m2008;
    in_valid   = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    act = {out_invalid, out_overflow, out_underflow, out_inexact, out_data};
    chk(out_valid && act == ex, tag_of(x, m2008, ex), act, ex);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired, actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    longint unsigned lf;
    logic [51:0]     fp;
    logic [35:0]     ea, eb, act;
    logic [63:0]     va, vb;
    lf         = 64'h9E3779B97F4A7C15;
    in_valid   = 1'b0;
    in_data    = '0;
    in_nan2008 = 1'b0;
    out_ready  = 1'b1;
    rst_n      = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!out_valid, "R11", {35'd0, out_valid}, 36'd0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(!out_valid && in_ready, "R11", {34'd0, out_valid, in_ready}, 36'd1);

    // every exponent code, both signs, rounding-critical fractions
    for (int e = 0; e < 2047; e++) begin
      for (int p = 0; p < 8; p++) begin
        lf = lf ^ (lf << 13);
        lf = lf ^ (lf >> 7);
        lf = lf ^ (lf << 17);
        case (p)
          0: fp = 52'd0;
          1: fp = {52{1'b1}};
          2: fp = 52'd1 << 28;
          3: fp = (52'd1 << 29) | (52'd1 << 28);
          4: fp = (52'd1 << 28) | 52'd1;
          5: fp = (52'd1 << 28) - 52'd1;
          6: fp = lf[51:0];
          default: fp = 52'd1;
        endcase
        for (int s = 0; s < 2; s++) begin
          run_vec({s[0], e[10:0], fp}, e[0]);
        end
      end
    end

    // NaN payloads and infinity under both encodings
    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 2; s++) begin
        for (int hi = 0; hi < 16; hi++) begin
          for (int lo = 0; lo < 4; lo++) begin
            case (lo)
              0: fp = {hi[3:0], 48'd0};
              1: fp = {hi[3:0], 48'd1};
              2: fp = {hi[3:0], 48'h0000_2000_0000};
              default: fp = {hi[3:0], 48'hA5A5_5A5A_C3C3};
            endcase
            run_vec({s[0], 11'h7FF, fp}, m[0]);
          end
        end
        run_vec({s[0], 63'd0}, m[0]);
      end
    end

    // back-pressure: hold result A, queue B behind it
    va = 64'h3FF0_0000_1000_0000;
    vb = 64'hC00A_AAAA_AAAA_AAAA;
    ea = ref_cvt(va, 1'b0);
    eb = ref_cvt(vb, 1'b0);
    @(negedge clk);
    out_ready  = 1'b0;
    in_nan2008 = 1'b0;
    in_data    = va;
    in_valid   = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk(out_valid && !in_ready, "R1", {34'd0, out_valid, in_ready}, 36'd2);
    in_data = vb;
    @(posedge clk);
    @(negedge clk);
    act = {out_invalid, out_overflow, out_underflow, out_inexact, out_data};
    chk(out_valid && act == ea, "R1", act, ea);
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    act = {out_invalid, out_overflow, out_underflow, out_inexact, out_data};
    chk(out_valid && act == eb, "R1", act, eb);
    @(posedge clk);
    @(negedge clk);
    chk(!out_valid && in_ready, "R1", {34'd0, out_valid, in_ready}, 36'd1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule